// File: doc/BRIEF.md
# Interpolating Tone-Remap Lookup Table

This block remaps every 8-bit pixel component through a programmable one-dimensional curve of up to 255 points. Each point is a 10-bit unsigned fixed-point value with 1 integer bit and 9 fraction bits. The input code is placed on the curve's axis, and the output is a linear blend of the two neighbouring points. The blended value is then used in one of two ways. In direct mode it is the output level, with 1.0 meaning full scale. In gain mode it is a multiplier applied to the input code.

Software fills a shadow copy of the table through a write port and sets the mode and the number of points in use. All of these take effect together on a single commit strobe, issued between frames. Pixels flow through a three-stage valid/ready pipeline. A word that never changes reports the fixed-point format of the table entries.

The stream follows these back-pressure rules. A transfer happens on any clock edge where valid and ready are both high. When the output is stalled (`m_valid` high, `m_ready` low), the whole pipeline freezes: `m_pix` holds its value and `s_ready` drops. `s_ready` is high exactly when the output register is empty or is being drained. A cycle with no input leaves a bubble in the pipeline.

Top module: `tone_lut_interp`

## Requirements
- R1: `cap_word` always reads 0x010001FF. Bits 27:24 hold the integer-bit count (1), bits 8:0 are a mask of the 9 fraction bits, and all other bits are zero.
- R2: A table write with `tbl_we` high and `tbl_addr` below 255 stores `tbl_wdata[9:0]` in the shadow entry at that address. Bits 31:10 of the data are ignored, and writes to address 255 are dropped.
- R3: Shadow writes, `cfg_mode` and `cfg_entries` have no effect on the pixel stream until `cfg_commit` is pulsed. The commit copies the whole shadow table and latches the mode and point count in one edge.
- R4: The committed point count N is `cfg_entries` clamped to the range 2..255. Values 0 and 1 act as 2.
- R5: For input x, the block forms p = x·(N−1), i = p div 255 and f = p mod 255. The blended value is y = (T[i]·(255−f) + T[i+1]·f + 127) div 255, and T[i+1] is not used when f = 0.
- R6: When `cfg_mode` is committed as any value other than 2'b10 (direct; 2'b01 is the nominal code), the output is min(255, (y·255 + 256) >> 9).
- R7: When `cfg_mode` is committed as 2'b10 (gain), the output is min(255, (x·y + 256) >> 9).
- R8: With `m_ready` held high, a pixel accepted on edge k is presented on `m_pix` with `m_valid` high after edge k+2. Results leave in the order the pixels arrived.
- R9: While `m_valid` is high and `m_ready` is low, `m_valid` and `m_pix` hold steady and `s_ready` is low. No pixel is lost or duplicated under any ready pattern.
- R10: After reset, `m_valid` is low, `s_ready` is high, the committed table is all zero, the mode is direct and N is 255, so every pixel maps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Shadow table write enable |
| tbl_addr | input | IDX_W (8) | Shadow table entry index |
| tbl_wdata | input | 32 | Entry word; bits 9:0 hold the 1.9 value |
| cfg_mode | input | 2 | Mode to commit: 2'b10 gain, otherwise direct |
| cfg_entries | input | IDX_W (8) | Point count to commit |
| cfg_commit | input | 1 | Pulse: apply shadow table, mode and count |
| cap_word | output | 32 | Format capability word |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Block accepts an input pixel |
| s_pix | input | PIX_W (8) | Input component |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream accepts the output pixel |
| m_pix | output | PIX_W (8) | Remapped component |

## Verification
The assertions take for granted that `cfg_commit` is pulsed only while no pixel is in flight: the pipeline stages are empty and no input is being offered. This is the between-frames rule, and one assertion flags any commit that breaks it. The bench therefore commits only after a sweep has drained every expected result, and never writes or commits while a stream is running. Ready patterns from a shift register exercise the stall rules during sweeps of all 256 input codes.

// File: rtl/tlut_pkg.sv
package tlut_pkg;
  localparam int PIX_W   = 8;
  localparam int ENT_W   = 10;
  localparam int FRAC_W  = 9;
  localparam int INT_W   = ENT_W - FRAC_W;
  localparam int MAX_ENT = 255;
  localparam int IDX_W   = 8;

  localparam logic [31:0] CAP_WORD =
    (32'(INT_W) << 24) | 32'((1 << FRAC_W) - 1);

  typedef enum logic {
    BL_DIRECT = 1'b0,
    BL_GAIN   = 1'b1
  } blend_e;
endpackage

// File: rtl/tlut_table.sv
module tlut_table #(
  parameter int MAX_ENT = 255,
  parameter int ENT_W   = 10,
  parameter int IDX_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [ENT_W-1:0] wr_data,
  input  logic             commit,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ENT_W-1:0] rd_lo,
  output logic [ENT_W-1:0] rd_hi
);
  logic [ENT_W-1:0] shadow [MAX_ENT];
  logic [ENT_W-1:0] live   [MAX_ENT];
  logic [IDX_W-1:0] hi_idx;

  // One storage slot per entry: shadow takes writes, live takes commits.
  for (genvar e = 0; e < MAX_ENT; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow[e] <= '0;
        live[e]   <= '0;
      end else begin
        if (wr_en && (wr_addr == IDX_W'(e))) shadow[e] <= wr_data;
        if (commit) live[e] <= shadow[e];
      end
    end
  end

  // The upper neighbour saturates at the last slot; its weight is zero there.
  assign hi_idx = (rd_idx == IDX_W'(MAX_ENT - 1)) ? rd_idx : rd_idx + 1'b1;
  assign rd_lo  = live[rd_idx];
  assign rd_hi  = live[hi_idx];

  // R3: the live table only moves on a commit.
  a_r3_live_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(live[MAX_ENT-1]) && $stable(live[0]));
endmodule

// File: rtl/tlut_locate.sv
module tlut_locate #(
  parameter int PIX_W = 8,
  parameter int IDX_W = 8
) (
  input  logic [PIX_W-1:0] pix,
  input  logic [IDX_W-1:0] npts,
  output logic [IDX_W-1:0] seg,
  output logic [PIX_W-1:0] wt
);
  localparam int POS_W = PIX_W + IDX_W;
  localparam int FULL  = (1 << PIX_W) - 1;

  logic [POS_W-1:0] pos;

  // Scale the input onto the (N-1) segments of the curve.
  always_comb begin
    pos = POS_W'(pix) * POS_W'(npts - 1'b1);
    seg = IDX_W'(pos / POS_W'(FULL));
    wt  = PIX_W'(pos % POS_W'(FULL));
  end
endmodule

// File: rtl/tlut_blend.sv
module tlut_blend #(
  parameter int PIX_W  = 8,
  parameter int ENT_W  = 10,
  parameter int FRAC_W = 9
) (
  input  logic [PIX_W-1:0] pix,
  input  logic [ENT_W-1:0] lo,
  input  logic [ENT_W-1:0] hi,
  input  logic [PIX_W-1:0] wt,
  input  tlut_pkg::blend_e mode,
  output logic [ENT_W-1:0] y,
  output logic [PIX_W-1:0] res
);
  localparam int FULL  = (1 << PIX_W) - 1;
  localparam int ACC_W = ENT_W + PIX_W + 1;
  localparam int SC_W  = ENT_W + PIX_W;

  logic [ACC_W-1:0] acc;
  logic [SC_W-1:0]  prod;
  logic [SC_W-1:0]  lvl;

  always_comb begin
    // Weighted blend of the two neighbours, rounded to nearest.
    acc = ACC_W'(lo) * ACC_W'(PIX_W'(FULL) - wt)
        + ACC_W'(hi) * ACC_W'(wt)
        + ACC_W'(FULL / 2);
    y   = ENT_W'(acc / ACC_W'(FULL));
    // Gain scales the input code; direct treats 1.0 as full scale.
    if (mode == tlut_pkg::BL_GAIN) prod = SC_W'(pix) * SC_W'(y);
    else                           prod = SC_W'(y) * SC_W'(FULL);
    lvl = (prod + SC_W'(1 << (FRAC_W - 1))) >> FRAC_W;
    res = (lvl > SC_W'(FULL)) ? PIX_W'(FULL) : PIX_W'(lvl);
  end
endmodule

// File: rtl/tone_lut_interp.sv
module tone_lut_interp #(
  parameter int PIX_W   = tlut_pkg::PIX_W,
  parameter int ENT_W   = tlut_pkg::ENT_W,
  parameter int FRAC_W  = tlut_pkg::FRAC_W,
  parameter int MAX_ENT = tlut_pkg::MAX_ENT,
  parameter int IDX_W   = tlut_pkg::IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbl_we,
  input  logic [IDX_W-1:0] tbl_addr,
  input  logic [31:0]      tbl_wdata,
  input  logic [1:0]       cfg_mode,
  input  logic [IDX_W-1:0] cfg_entries,
  input  logic             cfg_commit,
  output logic [31:0]      cap_word,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [PIX_W-1:0] s_pix,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [PIX_W-1:0] m_pix
);
  import tlut_pkg::*;

  // Committed configuration.
  blend_e           cur_mode;
  logic [IDX_W-1:0] cur_n;
  logic [IDX_W:0]   req_n;
  logic [IDX_W-1:0] next_n;

  // Pipeline state.
  logic             adv;
  logic             v1, v2, v3;
  logic [PIX_W-1:0] p1, p2;
  logic [IDX_W-1:0] seg1;
  logic [PIX_W-1:0] wt1, wt2;
  logic [ENT_W-1:0] lo2, hi2;
  logic [PIX_W-1:0] out3;

  logic [IDX_W-1:0] loc_seg;
  logic [PIX_W-1:0] loc_wt;
  logic [ENT_W-1:0] tb_lo, tb_hi;
  logic [ENT_W-1:0] bl_y;
  logic [PIX_W-1:0] bl_res;
  logic             wdata_unused;

  assign cap_word     = CAP_WORD;
  assign wdata_unused = ^tbl_wdata[31:ENT_W];

  // Clamp the requested point count to 2..MAX_ENT.
  always_comb begin
    req_n = {1'b0, cfg_entries};
    if (req_n < (IDX_W+1)'(2))             next_n = IDX_W'(2);
    else if (req_n > (IDX_W+1)'(MAX_ENT))  next_n = IDX_W'(MAX_ENT);
    else                                   next_n = cfg_entries;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_mode <= BL_DIRECT;
      cur_n    <= IDX_W'(MAX_ENT);
    end else if (cfg_commit) begin
      cur_mode <= (cfg_mode == 2'b10) ? BL_GAIN : BL_DIRECT;
      cur_n    <= next_n;
    end
  end

  tlut_table #(.MAX_ENT(MAX_ENT), .ENT_W(ENT_W), .IDX_W(IDX_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_we && (tbl_addr < IDX_W'(MAX_ENT))),
    .wr_addr (tbl_addr),
    .wr_data (tbl_wdata[ENT_W-1:0]),
    .commit  (cfg_commit),
    .rd_idx  (seg1),
    .rd_lo   (tb_lo),
    .rd_hi   (tb_hi)
  );

  tlut_locate #(.PIX_W(PIX_W), .IDX_W(IDX_W)) u_locate (
    .pix  (s_pix),
    .npts (cur_n),
    .seg  (loc_seg),
    .wt   (loc_wt)
  );

  tlut_blend #(.PIX_W(PIX_W), .ENT_W(ENT_W), .FRAC_W(FRAC_W)) u_blend (
    .pix  (p2),
    .lo   (lo2),
    .hi   (hi2),
    .wt   (wt2),
    .mode (cur_mode),
    .y    (bl_y),
    .res  (bl_res)
  );

  // Whole-pipe stall: every stage moves only when the output can drain.
  assign adv     = !v3 || m_ready;
  assign s_ready = adv;
  assign m_valid = v3;
  assign m_pix   = out3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      p1 <= '0; seg1 <= '0; wt1 <= '0;
      p2 <= '0; wt2 <= '0; lo2 <= '0; hi2 <= '0;
      out3 <= '0;
    end else if (adv) begin
      v1   <= s_valid;
      p1   <= s_pix;
      seg1 <= loc_seg;
      wt1  <= loc_wt;
      v2   <= v1;
      p2   <= p1;
      wt2  <= wt1;
      lo2  <= tb_lo;
      hi2  <= tb_hi;
      v3   <= v2;
      out3 <= bl_res;
    end
  end

  // R3: commits arrive only while nothing is in flight.
  a_r3_commit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_commit |-> !(v1 || v2 || v3 || s_valid));

  // R5: the located segment stays inside the curve; the last point carries no weight.
  a_r5_seg_range: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |-> (seg1 < cur_n) && ((seg1 != cur_n - 1'b1) || (wt1 == '0)));

  // R5: equal neighbours blend to themselves.
  a_r5_flat_blend: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && (lo2 == hi2)) |-> (bl_y == lo2));

  // R9: a stalled output holds.
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> m_valid && $stable(m_pix));

  // R9: an empty output never blocks the input.
  a_r9_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !m_valid |-> s_ready);
endmodule

// File: tb/tb_tone_lut_interp.sv
`timescale 1ns/1ps
module tb_tone_lut_interp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [7:0]  tbl_addr = '0;
  logic [31:0] tbl_wdata = '0;
  logic [1:0]  cfg_mode = 2'b01;
  logic [7:0]  cfg_entries = 8'd255;
  logic        cfg_commit = 1'b0;
  logic [31:0] cap_word;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [7:0]  s_pix = '0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [7:0]  m_pix;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  int shadow_m [255];
  int live_m   [255];
  int n_m      = 255;
  bit gain_m   = 1'b0;

  always #2.5 clk = ~clk;

  tone_lut_interp dut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .cfg_mode(cfg_mode), .cfg_entries(cfg_entries),
    .cfg_commit(cfg_commit), .cap_word(cap_word), .s_valid(s_valid),
    .s_ready(s_ready), .s_pix(s_pix), .m_valid(m_valid), .m_ready(m_ready),
    .m_pix(m_pix)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expect_out(input int x);
    int p, i, f, a, b, y, o;
    p = x * (n_m - 1);
    i = p / 255;
    f = p % 255;
    a = live_m[i];
    b = (f == 0) ? a : live_m[i + 1];
    y = (a * (255 - f) + b * f + 127) / 255;
    if (gain_m) o = (x * y + 256) >> 9;
    else        o = (y * 255 + 256) >> 9;
    return (o > 255) ? 255 : o;
  endfunction

  task automatic write_entry(input int addr, input int data);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = addr[7:0]; tbl_wdata = data;
    @(negedge clk);
    tbl_we = 1'b0;
    if (addr < 255) shadow_m[addr] = data & 1023;
  endtask

  task automatic commit_cfg(input logic [1:0] mode, input int ents);
    @(negedge clk);
    cfg_mode = mode; cfg_entries = ents[7:0]; cfg_commit = 1'b1;
    @(negedge clk);
    cfg_commit = 1'b0;
    for (int k = 0; k < 255; k++) live_m[k] = shadow_m[k];
    gain_m = (mode == 2'b10);
    n_m = (ents < 2) ? 2 : ents;
  endtask

  // Stream nsamp pixels; stride picks the order, bp enables a ready pattern.
  task automatic sweep(input string tag, input int nsamp, input int stride, input bit bp);
    int q[$];
    int sent = 0, got = 0;
    logic [7:0] lf = 8'h5B;
    bit held = 1'b0;
    int held_pix = 0;
    while (got < nsamp) begin
      @(negedge clk);
      if (held) begin
        check({tag, " R9 hold valid"}, int'(m_valid), 1);
        check({tag, " R9 hold data"}, int'(m_pix), held_pix);
      end
      m_ready = bp ? lf[0] | lf[3] : 1'b1;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      s_valid = (sent < nsamp);
      s_pix = 8'((sent * stride + 13) % 256);
      #1;
      held = m_valid && !m_ready;
      held_pix = int'(m_pix);
      if (held) check({tag, " R9 ready low"}, int'(s_ready), 0);
      if (m_valid && m_ready) begin
        if (q.size() == 0) check({tag, " R9 extra output"}, 1, 0);
        else check(tag, int'(m_pix), q.pop_front());
        got++;
      end
      if (s_valid && s_ready) begin
        q.push_back(expect_out(int'(s_pix)));
        sent++;
      end
    end
    s_valid = 1'b0;
    m_ready = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 255; k++) begin shadow_m[k] = 0; live_m[k] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state, R1 capability word.
    check("R10 m_valid after reset", int'(m_valid), 0);
    check("R10 s_ready after reset", int'(s_ready), 1);
    check("R1 cap_word", int'(cap_word), 32'h010001FF);
    check("R1 integer field", int'(cap_word[27:24]), 1);
    sweep("R10 zero table", 256, 1, 1'b0);

    // R3: a full shadow load is invisible before the commit.
    for (int k = 0; k < 255; k++) write_entry(k, (k * 1023) / 254);
    sweep("R3 before commit", 256, 1, 1'b0);
    commit_cfg(2'b01, 255);
    sweep("R5 R6 ramp N255", 256, 1, 1'b0);

    // R2: high data bits dropped, address 255 ignored; R9 under stalls.
    for (int k = 0; k < 17; k++) write_entry(k, 32'hABC00000 | ((k * 173 + 41) % 1024));
    write_entry(255, 32'h3FF);
    commit_cfg(2'b01, 17);
    sweep("R2 R5 N17 stalled", 256, 97, 1'b1);

    // R7: gain mode, two points spanning 1.0 to just below 2.0.
    write_entry(0, 512);
    write_entry(1, 1023);
    commit_cfg(2'b10, 2);
    sweep("R7 gain N2", 256, 1, 1'b0);

    // R7 with nine points and back-pressure.
    for (int k = 0; k < 9; k++) write_entry(k, (k * 311 + 100) % 1024);
    commit_cfg(2'b10, 9);
    sweep("R7 gain N9 stalled", 256, 53, 1'b1);

    // R4: counts below two clamp; R6: mode 2'b11 is direct.
    commit_cfg(2'b11, 1);
    sweep("R4 R6 count 1", 256, 1, 1'b0);
    commit_cfg(2'b00, 0);
    sweep("R4 count 0", 256, 7, 1'b1);

    // R8: three-edge latency for a lone pixel.
    commit_cfg(2'b01, 255);
    @(negedge clk);
    s_valid = 1'b1; s_pix = 8'd200; m_ready = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    check("R8 after edge 1", int'(m_valid), 0);
    @(negedge clk);
    check("R8 after edge 2", int'(m_valid), 0);
    @(negedge clk);
    check("R8 after edge 3 valid", int'(m_valid), 1);
    check("R8 after edge 3 data", int'(m_pix), expect_out(200));
    @(negedge clk);
    check("R8 drained", int'(m_valid), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule